// File: doc/BRIEF.md
# Partial Word Store Lane Generator

This block converts byte-granular "store from here to the end of the word" and "store from the start of the word up to here" requests into a single aligned, byte-masked memory write command. Each request carries a byte address, a 32-bit data word and a form select. The low two address bits pick which byte lanes are written. The begin form writes from the addressed byte to the end of the word. The end form writes from the start of the word up to, but not including, the addressed byte. Memory is big-endian: byte offset 0 is data lane [31:24] and offset 3 is lane [7:0]. Because of this ordering, data never needs shifting. Only the byte enables differ between cases.

Every store is sent as one masked word write, and this includes the three-byte cases, so each store is atomic at the memory. An end-form request at an aligned address stores nothing. It still produces a command, with all byte enables low and a probe flag set, which asks memory to check write permission at that word.

Both the request side and the command side use valid/ready. A request is taken when `in_valid` and `in_ready` are both high. The command appears on the next cycle and stays stable until `cmd_ready` accepts it. `in_ready` is high whenever the single command slot is empty or is being drained in the same cycle, so a memory that never stalls sees one command per cycle.

Top module: `psw_store_lanes`

## Requirements
- R1: A begin-form request (`in_end`=0) with address bits [1:0]=0 produces byte enables 4'b1111. Enable bit i covers data bits [8i+7:8i], so bit 3 is byte offset 0.
- R2: A begin-form request with address bits [1:0]=1, 2 or 3 produces byte enables 4'b0111, 4'b0011 or 4'b0001 respectively, with the probe flag low.
- R3: An end-form request (`in_end`=1) with address bits [1:0]=1, 2 or 3 produces byte enables 4'b1000, 4'b1100 or 4'b1110 respectively, with the probe flag low.
- R4: An end-form request with address bits [1:0]=0 produces a command with byte enables 4'b0000 and `cmd_probe`=1. Every other request produces `cmd_probe`=0 and at least one enable set.
- R5: `cmd_data` lane i equals request data bits [8i+7:8i] when enable bit i is set, and is zero otherwise.
- R6: `cmd_addr` equals the request address with bits [1:0] cleared.
- R7: While `cmd_valid` is high and `cmd_ready` is low, every command output holds its value.
- R8: `in_ready` = !`cmd_valid` | `cmd_ready`. An accepted request is presented as the command on the next cycle, and commands leave in acceptance order.
- R9: While `rst_n` is low, and right after reset, `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | ADDR_W | Byte address of the request |
| in_data | input | 32 | Data word, big-endian lanes |
| in_end | input | 1 | 0 = begin form, 1 = end form |
| cmd_valid | output | 1 | Write command present |
| cmd_ready | input | 1 | Memory accepts the command |
| cmd_addr | output | ADDR_W | Word-aligned address |
| cmd_be | output | 4 | Byte enables, bit 3 = offset 0 |
| cmd_data | output | 32 | Lane-placed write data, unused lanes zero |
| cmd_probe | output | 1 | Probe-only command (no bytes written) |

## Verification
The assertions assume the memory side follows valid/ready. They assume that `in_valid`, the request fields and `cmd_ready` are known at every clock edge after reset. They make no assumption that an offered request is held while `in_ready` is low, so the stimulus is free to withdraw or change a request before it is taken. The bench drives all inputs half a cycle away from the active edge. It covers all eight form and offset combinations with the memory always ready, then random requests with `cmd_ready` toggled randomly, which exercises stalls, same-cycle drain-and-refill and idle gaps.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int LANES  = 4;
  localparam int OFF_W  = $clog2(LANES);
  localparam int DATA_W = 8 * LANES;

  typedef enum logic {
    FORM_BEGIN = 1'b0,
    FORM_END   = 1'b1
  } form_e;

  typedef struct packed {
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] data;
    logic              probe;
  } lane_cmd_t;
endpackage

// File: rtl/psw_lane_decode.sv
module psw_lane_decode
  import psw_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  input  form_e             form,
  input  logic [DATA_W-1:0] data,
  output lane_cmd_t         cmd
);
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] lanes;

  // Big-endian: enable bit i holds byte offset LANES-1-i.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] OFFS = OFF_W'(LANES - 1 - i);
    always_comb begin
      if (form == FORM_BEGIN) be[i] = (OFFS >= off);
      else                    be[i] = (OFFS < off);
    end
    assign lanes[8*i +: 8] = be[i] ? data[8*i +: 8] : 8'h00;
  end

  assign cmd.be    = be;
  assign cmd.data  = lanes;
  assign cmd.probe = (form == FORM_END) && (off == '0);
endmodule

// File: rtl/psw_cmd_hold.sv
module psw_cmd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);
  logic         vld_q;
  logic [W-1:0] pay_q;

  assign in_ready    = !vld_q || out_ready;
  assign out_valid   = vld_q;
  assign out_payload = pay_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pay_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) pay_q <= in_payload;
    end
  end

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));

  assert_accept_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_payload == $past(in_payload)));

  assert_idle_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid);
endmodule

// File: rtl/psw_store_lanes.sv
module psw_store_lanes
  import psw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [31:0]       in_data,
  input  logic              in_end,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [3:0]        cmd_be,
  output logic [31:0]       cmd_data,
  output logic              cmd_probe
);
  localparam int PAY_W = ADDR_W + $bits(lane_cmd_t);

  lane_cmd_t        dec_cmd, out_cmd;
  logic [ADDR_W-1:0] word_addr;
  logic [PAY_W-1:0]  pay_in, pay_out;
  form_e             form;

  assign form      = in_end ? FORM_END : FORM_BEGIN;
  assign word_addr = {in_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  psw_lane_decode u_decode (
    .off  (in_addr[OFF_W-1:0]),
    .form (form),
    .data (in_data),
    .cmd  (dec_cmd)
  );

  assign pay_in = {word_addr, dec_cmd};

  psw_cmd_hold #(.W(PAY_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_payload  (pay_in),
    .out_valid   (cmd_valid),
    .out_ready   (cmd_ready),
    .out_payload (pay_out)
  );

  assign cmd_addr  = pay_out[PAY_W-1 -: ADDR_W];
  assign out_cmd   = pay_out[$bits(lane_cmd_t)-1:0];
  assign cmd_be    = out_cmd.be;
  assign cmd_data  = out_cmd.data;
  assign cmd_probe = out_cmd.probe;

  assert_probe_no_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_probe) |-> (cmd_be == 4'b0000));

  assert_store_has_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_probe) |-> (cmd_be != 4'b0000));

  assert_aligned_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr[1:0] == 2'b00));

  assert_off_lanes_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_data & ~{{8{cmd_be[3]}}, {8{cmd_be[2]}},
                                 {8{cmd_be[1]}}, {8{cmd_be[0]}}}) == 32'h0));

  assert_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_end) |=> cmd_be[0]);

  assert_end_from_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_end && in_addr[1:0] != 2'b00) |=> cmd_be[3]);
endmodule

// File: tb/tb_psw_store_lanes.sv
module tb_psw_store_lanes;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        in_end = 1'b0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_addr;
  logic [3:0]  cmd_be;
  logic [31:0] cmd_data;
  logic        cmd_probe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  psw_store_lanes #(.ADDR_W(32)) dut (.*);

  typedef struct {
    logic [31:0] a;
    logic [3:0]  be;
    logic [31:0] d;
    logic        p;
    string       tag;
  } exp_t;

  exp_t q[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] d,
                                 input logic e);
    exp_t r;
    r.a = a & ~32'd3;
    r.p = 1'b0;
    if (!e) begin
      case (a[1:0])
        2'd0: begin r.be = 4'b1111; r.tag = "R1"; end
        2'd1: begin r.be = 4'b0111; r.tag = "R2"; end
        2'd2: begin r.be = 4'b0011; r.tag = "R2"; end
        default: begin r.be = 4'b0001; r.tag = "R2"; end
      endcase
    end else begin
      case (a[1:0])
        2'd0: begin r.be = 4'b0000; r.p = 1'b1; r.tag = "R4"; end
        2'd1: begin r.be = 4'b1000; r.tag = "R3"; end
        2'd2: begin r.be = 4'b1100; r.tag = "R3"; end
        default: begin r.be = 4'b1110; r.tag = "R3"; end
      endcase
    end
    r.d = 32'h0;
    for (int i = 0; i < 4; i++)
      if (r.be[i]) r.d[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // One cycle: drive at negedge, compare, advance model across the next edge.
  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] d,
                      input logic e, input logic rdy);
    bit fin, fout;
    @(negedge clk);
    in_valid = v; in_addr = a; in_data = d; in_end = e; cmd_ready = rdy;
    #1;
    check(cmd_valid == (q.size() != 0), "R8", 64'(cmd_valid), 64'(q.size() != 0));
    check(in_ready == (q.size() == 0 || rdy), "R8", 64'(in_ready),
          64'(q.size() == 0 || rdy));
    if (q.size() != 0) begin
      check(cmd_addr == q[0].a, "R6", 64'(cmd_addr), 64'(q[0].a));
      check(cmd_be == q[0].be, q[0].tag, 64'(cmd_be), 64'(q[0].be));
      check(cmd_data == q[0].d, "R5", 64'(cmd_data), 64'(q[0].d));
      check(cmd_probe == q[0].p, "R4", 64'(cmd_probe), 64'(q[0].p));
    end
    fout = cmd_valid && rdy;
    fin  = v && (q.size() == 0 || rdy);
    if (fout && q.size() != 0) void'(q.pop_front());
    if (fin) q.push_back(model(a, d, e));
  endtask

  initial begin
    // R9: reset holds the command side idle
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cmd_valid == 1'b0, "R9", 64'(cmd_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_valid == 1'b0, "R9", 64'(cmd_valid), 64'd0);

    // Every form and offset, memory always ready (R1..R6)
    for (int f = 0; f < 2; f++)
      for (int o = 0; o < 4; o++)
        step(1'b1, 32'h1234_5670 + 32'(o), 32'hA1B2_C3D4, f[0], 1'b1);
    step(1'b0, '0, '0, 1'b0, 1'b1);

    // Stall: command held while memory not ready (R7)
    step(1'b1, 32'h0000_0101, 32'hDEAD_BEEF, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++)
      step(1'b1, 32'h0000_0203, 32'h1111_2222, 1'b1, 1'b0);
    step(1'b0, '0, '0, 1'b0, 1'b1);
    step(1'b0, '0, '0, 1'b0, 1'b1);

    // Random traffic with random back-pressure
    for (int k = 0; k < 2000; k++)
      step(($urandom % 4) != 0, $urandom, $urandom, $urandom % 2,
           ($urandom % 3) != 0);
    for (int k = 0; k < 3; k++) step(1'b0, '0, '0, 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule